// File: doc/BRIEF.md
# Handshaked SPI Master

This block is a single-slave SPI master driven from the system clock. The host gives it an 8-bit word and a start request. The block shifts the word out on MOSI, MSB first, and at the same time captures a word from MISO. The captured word is returned with a one-cycle done pulse. The bit clock has a half period of N+1 system clocks, where N is an 8-bit prescale value. All four polarity/phase combinations are supported. Configuration is latched when a start is accepted.

A configuration input selects one of two framing options.

- **Enable mode.** The slave paces the master through an active-high ready input. The master holds its first clock edge until that input, after a two-flop synchronizer, is seen high. The master then waits a short fixed hold-off before clocking.
- **Chip-select mode.** The master drives an active-low select. It keeps that select asserted for a fixed two-cycle setup plus a 5-bit programmable count D before its first edge.

In both modes, phase 1 adds half a bit period in front of the first edge. After the final edge a short tail runs before done. The tail is one cycle for phase 1 and N+2 cycles for phase 0. It gives the slave a window to withdraw its ready signal before a queued word begins.

Top module: `spi_hs_master`

## Requirements
- R1: The bit clock rests at the polarity level while idle. Its first edge in a transfer is rising for polarity 0 and falling for polarity 1. Successive edges are N+1 system clocks apart.
- R2: MOSI carries the latched tx_data MSB first. With phase 0, MISO is captured on the leading (odd-numbered) edges and MOSI changes on the trailing edges. With phase 1, MOSI changes on every leading edge after the first, and MISO is captured on the trailing edges. From the done cycle on, rx_data holds the 8 captured bits, first captured bit in bit 7.
- R3: In enable mode (cfg_cs_mode=0), cs_n stays high and the bit clock does not move while slv_en is low. The first edge comes on the third system-clock edge after the first edge that samples slv_en high. Phase 1 adds a further N+1 cycles.
- R4: In chip-select mode (cfg_cs_mode=1), cs_n goes low on the clock edge that accepts start. It stays low through every bit-clock edge. The first bit-clock edge comes 2+D cycles after that acceptance edge, plus N+1 cycles for phase 1. slv_en has no effect in this mode.
- R5: Done rises a set number of cycles after the last bit-clock edge: 1 cycle for phase 1, N+2 cycles for phase 0. cs_n is high in the done cycle.
- R6: Done is high for exactly one cycle. Busy is high from the cycle after start is accepted until done rises, and is low while done is high. Start is accepted whenever busy is low, including the done cycle.
- R7: In enable mode, a word accepted in the done cycle begins only if the synchronized slv_en is high when checked after acceptance. If slv_en stays high, the first edge comes on the second edge after acceptance, plus N+1 cycles for phase 1. If the slave drops slv_en no later than the final bit-clock edge, no edge occurs until slv_en rises again; the R3 timing then applies.
- R8: Each transfer makes exactly 16 bit-clock edges and leaves the clock at the polarity level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cs_mode | input | 1 | 0: slave enable handshake, 1: master chip select |
| cfg_cpol | input | 1 | Clock polarity (idle level) |
| cfg_cpha | input | 1 | Clock phase |
| cfg_prescale | input | 8 | N: half bit period is N+1 system clocks |
| cfg_cs_delay | input | 5 | D: extra select-to-clock cycles |
| start | input | 1 | Accept tx_data and begin a word when not busy |
| tx_data | input | 8 | Word to send |
| busy | output | 1 | Word in progress |
| done | output | 1 | One-cycle pulse at word completion |
| rx_data | output | 8 | Received word |
| slv_en | input | 1 | Slave ready, active high, asynchronous |
| sclk | output | 1 | Bit clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The hardest case to reach is the re-sampling window between chained words. The slave must withdraw its ready input near the final bit-clock edge. The host must already have the next start waiting in the done cycle. Only then does a stale synchronizer value show up as a premature first edge. The bench chains runs back to back and drops slv_en at the moment it sees the sixteenth edge. It then raises slv_en again after a chosen delay and checks that the first edge lands exactly where the R3 timing puts it. Random runs mix held and dropped enables with chip-select words, over random prescale, delay, mode and data.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL
  } state_t;

  // half bit period in system clocks
  function automatic int half_cycles(int pre);
    return pre + 1;
  endfunction

  // select-active to first edge, chip-select framing
  function automatic int cs_lead_cycles(bit cpha, int pre, int dly, int setup);
    return setup + dly + (cpha ? half_cycles(pre) : 0);
  endfunction

  // cycles spent in the lead state once the synchronized enable is seen;
  // the synchronizer stages make up the rest of the hold-off
  function automatic int en_lead_cycles(bit cpha, int pre, int hold, int stages);
    return (hold - stages) + (cpha ? half_cycles(pre) : 0);
  endfunction

  // final edge to done pulse
  function automatic int tail_cycles(bit cpha, int pre);
    return cpha ? 1 : half_cycles(pre) + 1;
  endfunction

endpackage

// File: rtl/spi_hs_sync.sv
module spi_hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '0;
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/spi_hs_timer.sv
module spi_hs_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/spi_hs_shifter.sv
module spi_hs_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_word,
  input  logic          shift_out,
  input  logic          sample_in,
  input  logic          miso,
  output logic          mosi,
  output logic [DW-1:0] rx_word
);
  logic [DW-1:0] tx_sh;
  logic [DW-1:0] rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      if (load)           tx_sh <= load_word;
      else if (shift_out) tx_sh <= {tx_sh[DW-2:0], 1'b0};
      if (sample_in)      rx_sh <= {rx_sh[DW-2:0], miso};
    end
  end

  assign mosi    = tx_sh[DW-1];
  assign rx_word = rx_sh;
endmodule

// File: rtl/spi_hs_master.sv
module spi_hs_master
  import spi_hs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PRE_W       = 8,
  parameter int DLY_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int EN_HOLD     = 3,
  parameter int CS_SETUP    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cs_mode,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [PRE_W-1:0]  cfg_prescale,
  input  logic [DLY_W-1:0]  cfg_cs_delay,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  input  logic              slv_en,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  localparam int WIDEST = (PRE_W > DLY_W) ? PRE_W : DLY_W;
  localparam int CNT_W  = WIDEST + 2;
  localparam int EDGES  = 2 * DATA_W;
  localparam int EIW    = $clog2(EDGES + 1);

  state_t             st;
  logic               mode_q, cpol_q, cpha_q;
  logic [PRE_W-1:0]   pre_q;
  logic [EIW-1:0]     edge_idx;
  logic               sclk_q, done_q;
  logic [DATA_W-1:0]  rx_q, rx_word;
  logic               en_s, tmr_zero, tmr_load;
  logic [CNT_W-1:0]   tmr_val;

  // named internal events
  logic in_idle, in_wait, in_lead, in_shift, in_tail;
  logic start_ok, lead_go, edge_evt, last_edge, do_sample, do_shift;

  assign in_idle  = (st == ST_IDLE);
  assign in_wait  = (st == ST_WAIT);
  assign in_lead  = (st == ST_LEAD);
  assign in_shift = (st == ST_SHIFT);
  assign in_tail  = (st == ST_TAIL);

  assign start_ok  = in_idle && start;
  assign lead_go   = in_wait && en_s;
  assign edge_evt  = (in_lead || in_shift) && tmr_zero;
  assign last_edge = edge_evt && (edge_idx == EIW'(EDGES - 1));
  assign do_sample = edge_evt && (cpha_q ? edge_idx[0] : !edge_idx[0]);
  assign do_shift  = edge_evt && (cpha_q ? (!edge_idx[0] && edge_idx != '0)
                                         : (edge_idx[0] && !last_edge));

  spi_hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .d (slv_en), .q (en_s)
  );

  spi_hs_timer #(.W(CNT_W)) u_tmr (
    .clk (clk), .rst_n (rst_n), .load (tmr_load), .load_val (tmr_val),
    .zero (tmr_zero)
  );

  spi_hs_shifter #(.DW(DATA_W)) u_shf (
    .clk (clk), .rst_n (rst_n), .load (start_ok), .load_word (tx_data),
    .shift_out (do_shift), .sample_in (do_sample), .miso (miso),
    .mosi (mosi), .rx_word (rx_word)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (start_ok) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(cs_lead_cycles(cfg_cpha, int'(cfg_prescale),
                                       int'(cfg_cs_delay), CS_SETUP) - 1);
    end else if (lead_go) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(en_lead_cycles(cpha_q, int'(pre_q),
                                       EN_HOLD, SYNC_STAGES) - 1);
    end else if (last_edge) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(tail_cycles(cpha_q, int'(pre_q)) - 1);
    end else if (edge_evt) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(half_cycles(int'(pre_q)) - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      mode_q   <= 1'b0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      pre_q    <= '0;
      edge_idx <= '0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          sclk_q <= cfg_cpol;
          if (start) begin
            mode_q   <= cfg_cs_mode;
            cpol_q   <= cfg_cpol;
            cpha_q   <= cfg_cpha;
            pre_q    <= cfg_prescale;
            edge_idx <= '0;
            st       <= cfg_cs_mode ? ST_LEAD : ST_WAIT;
          end
        end
        ST_WAIT:  if (en_s)      st <= ST_LEAD;
        ST_LEAD:  if (tmr_zero)  st <= ST_SHIFT;
        ST_SHIFT: if (last_edge) st <= ST_TAIL;
        ST_TAIL: begin
          if (tmr_zero) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
            rx_q   <= rx_word;
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (edge_evt) begin
        sclk_q   <= ~sclk_q;
        edge_idx <= edge_idx + 1'b1;
      end
    end
  end

  assign busy    = !in_idle;
  assign done    = done_q;
  assign rx_data = rx_q;
  assign sclk    = sclk_q;
  assign cs_n    = !(mode_q && (in_lead || in_shift || in_tail));
endmodule

// File: rtl/spi_hs_chk.sv
module spi_hs_chk #(
  parameter int EIW   = 5,
  parameter int EDGES = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           sclk,
  input logic           cs_n,
  input logic           cfg_cpol,
  input logic           mode_q,
  input logic           in_wait,
  input logic [EIW-1:0] edge_idx
);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !busy && !$past(busy) && $stable(cfg_cpol))
      |-> (sclk == cfg_cpol));

  // R8
  edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (edge_idx == EIW'(EDGES)));

  // R3
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && $past(in_wait)) |-> $stable(sclk));

  // R4
  cs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q && (sclk != $past(sclk))) |-> !cs_n);

  // R3
  en_mode_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |-> cs_n);
endmodule

bind spi_hs_master spi_hs_chk #(.EIW(EIW), .EDGES(EDGES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .sclk     (sclk),
  .cs_n     (cs_n),
  .cfg_cpol (cfg_cpol),
  .mode_q   (mode_q),
  .in_wait  (in_wait),
  .edge_idx (edge_idx)
);

// File: tb/spi_hs_master_tb.sv
module spi_hs_master_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_cs_mode = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [7:0] cfg_prescale = '0;
  logic [4:0] cfg_cs_delay = '0;
  logic       start = 1'b0;
  logic [7:0] tx_data = '0;
  logic       busy, done, sclk, mosi, cs_n;
  logic [7:0] rx_data;
  logic       slv_en = 1'b0;
  logic       miso = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  bit         armed = 0;
  int         sidx = 0;
  logic [7:0] sl_word = '0;
  logic [7:0] rxm = '0;
  bit         cur_cpol = 0, cur_cpha = 0;
  bit         en_level = 0;

  always #10 clk = ~clk;

  spi_hs_master u_dut (
    .clk (clk), .rst_n (rst_n), .cfg_cs_mode (cfg_cs_mode),
    .cfg_cpol (cfg_cpol), .cfg_cpha (cfg_cpha), .cfg_prescale (cfg_prescale),
    .cfg_cs_delay (cfg_cs_delay), .start (start), .tx_data (tx_data),
    .busy (busy), .done (done), .rx_data (rx_data), .slv_en (slv_en),
    .sclk (sclk), .mosi (mosi), .miso (miso), .cs_n (cs_n)
  );

  // slave model: captures MOSI, drives MISO, by edge number within a word
  always @(sclk) begin
    if (armed) begin
      sidx++;
      if (sclk != cur_cpol) begin
        if (cur_cpha) begin
          if (sidx > 1) miso = sl_word[7 - (sidx - 1) / 2];
        end else begin
          rxm = {rxm[6:0], mosi};
        end
      end else begin
        if (cur_cpha) rxm = {rxm[6:0], mosi};
        else if (sidx < 16) miso = sl_word[7 - sidx / 2];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_first(bit m, bit pha, int pre, int dly, int ea);
    int ph;
    ph = pha ? pre + 1 : 0;
    if (m) return dly + 2 + ph;
    if (ea < 0) return ph + 2;
    return ph + ea + 4;
  endfunction

  function automatic int exp_tail(bit pha, int pre);
    if (pha) return 1;
    return pre + 2;
  endfunction

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic run(input bit m, input bit pol, input bit pha, input int pre,
                     input int dly, input logic [7:0] tx, input logic [7:0] sw,
                     input int ea, input bit dr);
    int   tog = 0, first = -1, second = -1, last = -1, dcyc = -1;
    int   busybad = 0, csbad = 0;
    logic prev;
    logic dir = 1'b0;
    cfg_cs_mode = m; cfg_cpol = pol; cfg_cpha = pha;
    cfg_prescale = 8'(pre); cfg_cs_delay = 5'(dly);
    tx_data = tx; sl_word = sw; cur_cpol = pol; cur_cpha = pha;
    miso = sw[7];
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    sidx = 0; rxm = '0; armed = 1;
    chk(busy == 1'b1, "R6 busy after accept", busy, 1);
    chk(done == 1'b0, "R6 done width", done, 0);
    chk(cs_n == !m, "R4 R3 cs_n at accept", cs_n, !m);
    chk(sclk == pol, "R1 idle level", sclk, pol);
    prev = sclk;
    if (!m && ea == 0) begin slv_en = 1'b1; en_level = 1; end
    for (int c = 1; c < 20000 && dcyc < 0; c++) begin
      @(posedge clk); #1;
      if (sclk !== prev) begin
        tog++;
        prev = sclk;
        if (tog == 1) begin first = c; dir = sclk; end
        if (tog == 2) second = c;
        last = c;
        if (cs_n !== !m) csbad++;
        if (tog == 16 && !m && dr) begin slv_en = 1'b0; en_level = 0; end
      end
      if (done) dcyc = c;
      else if (!busy) busybad++;
      if (!m && ea > 0 && c == ea) begin slv_en = 1'b1; en_level = 1; end
    end
    armed = 0;
    if (dcyc < 0) chk(0, "R6 done never seen", 0, 1);
    chk(first == exp_first(m, pha, pre, dly, ea),
        m ? "R4 select to first edge" : (ea < 0 ? "R7 held enable start" : "R3 enable hold-off"),
        first, exp_first(m, pha, pre, dly, ea));
    chk(dir == !pol, "R1 first edge direction", dir, !pol);
    chk(second - first == pre + 1, "R1 half period", second - first, pre + 1);
    chk(tog == 16, "R8 edge count", tog, 16);
    chk(prev == pol, "R8 final level", prev, pol);
    chk(dcyc - last == exp_tail(pha, pre), "R5 tail length", dcyc - last, exp_tail(pha, pre));
    chk(cs_n == 1'b1, "R5 cs_n in done cycle", cs_n, 1);
    chk(busy == 1'b0, "R6 busy low with done", busy, 0);
    chk(busybad == 0, "R6 busy held", busybad, 0);
    chk(csbad == 0, "R4 R3 cs_n during clocking", csbad, 0);
    chk(rx_data == sw, "R2 received word", rx_data, sw);
    chk(rxm == tx, "R2 transmitted word", rxm, tx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_up();
  end

  initial begin
    bit   m, pol, pha, dr;
    int   pre, dly, ea;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk(busy == 1'b0, "R6 reset busy", busy, 0);
    chk(done == 1'b0, "R6 reset done", done, 0);
    chk(cs_n == 1'b1, "R4 reset cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R1 reset idle level", sclk, 0);

    // directed corners
    run(1, 0, 0, 1, 0, 8'hA5, 8'h3C, -2, 0);
    run(1, 1, 1, 3, 31, 8'h81, 8'h7E, -2, 0);
    run(0, 0, 1, 2, 0, 8'hC3, 8'h5A, 5, 1);
    // R7: enable dropped at the final edge of the previous word, start queued
    run(0, 1, 0, 0, 0, 8'h0F, 8'hF0, 12, 0);
    // R7: enable held high across the boundary
    run(0, 0, 0, 4, 0, 8'h96, 8'h69, -1, 0);
    // R4: enable high has no effect in chip-select mode
    run(1, 0, 1, 0, 7, 8'hFF, 8'h00, -2, 0);
    run(0, 1, 1, 1, 0, 8'h12, 8'h34, -1, 1);
    // R4: enable low has no effect either
    run(1, 1, 0, 255, 3, 8'h55, 8'hAA, -2, 0);
    run(1, 0, 1, 255, 0, 8'h01, 8'h80, -2, 0);

    for (int i = 0; i < 30; i++) begin
      m   = 1'($urandom_range(0, 1));
      pol = 1'($urandom_range(0, 1));
      pha = 1'($urandom_range(0, 1));
      pre = $urandom_range(0, 15);
      dly = $urandom_range(0, 31);
      dr  = 0;
      ea  = -2;
      if (!m) begin
        ea = en_level ? -1 : $urandom_range(0, 15);
        dr = 1'($urandom_range(0, 1));
      end
      run(m, pol, pha, pre, dly, 8'($urandom), 8'($urandom), ea, dr);
      if ($urandom_range(0, 3) == 0)
        repeat ($urandom_range(1, 3)) begin @(posedge clk); #1; end
    end
    finish_up();
  end
endmodule